// File: doc/BRIEF.md
# Minimal 16-bit Multicycle Processor Core

This block is a small 16-bit processor for control tasks. It reads one-word instructions from a 1K-word memory and executes them over several clock states. Each instruction is fetched, decoded and executed. Loads and stores then use a memory state, and instructions that write a register use a writeback state. The core has eight general-purpose registers, and R0 always reads as zero. There are also a program counter, a set of sign, zero and overflow flags, and an ALU.

Signed comparisons work by subtraction. A compare sets the flags, and a conditional branch then tests them. A subroutine call saves the return address in R7 instead of using a hardware stack, and a return reloads the PC from R7. A halt instruction freezes the core until the next reset. Instruction and data memory share a single port. Reads from that port are combinational, so read data for the address shown on `mem_addr_o` is valid in the same cycle.

Top module: `cpu16_core`

## Requirements
- R1: While `rst_ni` is low and directly after it rises, `halted_o` is 0, `mem_we_o` is 0 and `mem_addr_o` is 0, so the first fetch is from word 0.
- R2: The register form is op[15:12], rd[11:9], rs[8:6], rt[5:3]. Opcode 0 computes rd=rs+rt, 1 computes rd=rs-rt, 2 computes rd=rs&rt and 3 computes rd=rs|rt. Arithmetic wraps modulo 2^16.
- R3: The immediate form is op[15:12], rd[11:9], rs[8:6], imm[5:0]. Opcode 4 computes rd=rs+sext(imm), wrapping modulo 2^16.
- R4: Register R0 reads as zero, and any result written to R0 is discarded.
- R5: Opcode 5 loads rd from memory and opcode 6 stores rd to memory. Both use the immediate form, and the address is (rs+sext(imm)) truncated to 10 bits. A store raises `mem_we_o` for exactly one cycle and drives the address and the data of rd.
- R6: Opcode 8 (register form, rs and rt) sets the flags from rs-rt and writes no register. Opcode 7 is op[15:12], cond[11:9], off[8:0], and it branches to PC+1+sext(off) when the condition holds. The conditions are signed: 0 ==, 1 !=, 2 <, 3 >=, 4 >, 5 <=, 6 always, 7 never. An untaken branch falls through to the next word.
- R7: Opcode 9 writes PC+1 to R7 and jumps to the zero-extended target in bits [8:0]. Opcode 10 loads the PC from R7.
- R8: Opcode 15 stops the core. `halted_o` then stays 1, no store occurs, and `mem_addr_o` stays constant until reset. Opcodes 11 to 14 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | 10 | Word address for fetch, load and store |
| mem_wdata_o | output | 16 | Store data |
| mem_rdata_i | input | 16 | Read data for the address on `mem_addr_o`, valid in the same cycle |
| mem_we_o | output | 1 | Store strobe |
| halted_o | output | 1 | High once a halt has executed |

## Verification
The assertions assume that memory read data follows the address combinationally. They also assume that reset is applied before any program runs. The halt checks rely on the core never leaving the halted state without a reset. The stimulus fills every unused word with the halt opcode, so a stray jump ends the run instead of wandering. Programs use only the opcodes defined above, and each program ends in a halt before the next reset.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;
  localparam int unsigned NREG = 8;

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_SUB  = 4'd1;
  localparam logic [3:0] OP_AND  = 4'd2;
  localparam logic [3:0] OP_OR   = 4'd3;
  localparam logic [3:0] OP_ADDI = 4'd4;
  localparam logic [3:0] OP_LD   = 4'd5;
  localparam logic [3:0] OP_ST   = 4'd6;
  localparam logic [3:0] OP_BR   = 4'd7;
  localparam logic [3:0] OP_CMP  = 4'd8;
  localparam logic [3:0] OP_CALL = 4'd9;
  localparam logic [3:0] OP_RET  = 4'd10;
  localparam logic [3:0] OP_HALT = 4'd15;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB, ST_HALT
  } state_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_op_e;

  function automatic logic cond_met(input logic [2:0] c, input logic n, input logic z,
                                    input logic v);
    logic lt;
    lt = n ^ v;
    case (c)
      3'd0: return z;
      3'd1: return !z;
      3'd2: return lt;
      3'd3: return !lt;
      3'd4: return !z && !lt;
      3'd5: return z || lt;
      3'd6: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cpu16_alu.sv
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] y_o,
  output logic          n_o,
  output logic          z_o,
  output logic          v_o
);
  localparam int unsigned MSB = DW - 1;

  always_comb begin
    v_o = 1'b0;
    case (op_i)
      ALU_ADD: begin
        y_o = a_i + b_i;
        v_o = (a_i[MSB] == b_i[MSB]) && (y_o[MSB] != a_i[MSB]);
      end
      ALU_SUB: begin
        y_o = a_i - b_i;
        v_o = (a_i[MSB] != b_i[MSB]) && (y_o[MSB] != a_i[MSB]);
      end
      ALU_AND: y_o = a_i & b_i;
      default: y_o = a_i | b_i;
    endcase
    n_o = y_o[MSB];
    z_o = (y_o == '0);
  end
endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile
  import cpu16_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned NR = NREG
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [$clog2(NR)-1:0] waddr_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic [$clog2(NR)-1:0] raddr_a_i,
  input  logic [$clog2(NR)-1:0] raddr_b_i,
  output logic [DW-1:0]         rdata_a_o,
  output logic [DW-1:0]         rdata_b_o
);
  logic [DW-1:0] regs [NR];

  assign regs[0] = '0;

  for (genvar r = 1; r < NR; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs[r] <= '0;
      else if (we_i && waddr_i == r) regs[r] <= wdata_i;
    end
  end

  assign rdata_a_o = regs[raddr_a_i];
  assign rdata_b_o = regs[raddr_b_i];
endmodule

// File: rtl/cpu16_ctrl.sv
module cpu16_ctrl
  import cpu16_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] op_i,
  output state_e     state_o
);
  state_e state_d;

  always_comb begin
    state_d = state_o;
    case (state_o)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: state_d = ST_EXEC;
      ST_EXEC: begin
        case (op_i)
          OP_LD, OP_ST: state_d = ST_MEM;
          OP_ADD, OP_SUB, OP_AND, OP_OR, OP_ADDI, OP_CALL: state_d = ST_WB;
          OP_HALT: state_d = ST_HALT;
          default: state_d = ST_FETCH;
        endcase
      end
      ST_MEM:  state_d = (op_i == OP_LD) ? ST_WB : ST_FETCH;
      ST_WB:   state_d = ST_FETCH;
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= ST_FETCH;
    else state_o <= state_d;
  end
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_we_o,
  output logic          halted_o
);
  localparam int unsigned RW = $clog2(NREG);
  localparam logic [RW-1:0] LINK_REG = RW'(NREG - 1);

  state_e        state;
  logic [DW-1:0] ir_q, a_q, b_q, res_q, mdr_q;
  logic [AW-1:0] pc_q;
  logic          n_q, z_q, v_q;

  logic [3:0]    op;
  logic [RW-1:0] rd, rs, rt;
  logic [DW-1:0] imm_ext, alu_b, alu_y, rf_a, rf_b, wb_data;
  logic [AW-1:0] off_ext, tgt_ext;
  logic          alu_n, alu_z, alu_v, use_imm, sets_flags, rf_we;
  logic [RW-1:0] ra_sel, rb_sel, wa_sel;
  alu_op_e       alu_op;

  assign op      = ir_q[15:12];
  assign rd      = ir_q[11:9];
  assign rs      = ir_q[8:6];
  assign rt      = ir_q[5:3];
  assign imm_ext = {{(DW-6){ir_q[5]}}, ir_q[5:0]};
  assign off_ext = {{(AW-9){ir_q[8]}}, ir_q[8:0]};
  assign tgt_ext = {{(AW-9){1'b0}}, ir_q[8:0]};

  assign use_imm    = (op == OP_ADDI) || (op == OP_LD) || (op == OP_ST);
  assign sets_flags = (op == OP_SUB) || (op == OP_CMP);
  assign alu_b      = use_imm ? imm_ext : b_q;

  always_comb begin
    case (op)
      OP_SUB, OP_CMP: alu_op = ALU_SUB;
      OP_AND:         alu_op = ALU_AND;
      OP_OR:          alu_op = ALU_OR;
      default:        alu_op = ALU_ADD;
    endcase
  end

  // port a carries the link register on return, port b the store data
  assign ra_sel = (op == OP_RET) ? LINK_REG : rs;
  assign rb_sel = (op == OP_ST) ? rd : rt;
  assign wa_sel = (op == OP_CALL) ? LINK_REG : rd;
  assign wb_data = (op == OP_LD) ? mdr_q : res_q;
  assign rf_we  = (state == ST_WB);

  cpu16_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .state_o (state)
  );

  cpu16_regfile #(.DW(DW), .NR(NREG)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we),
    .waddr_i   (wa_sel),
    .wdata_i   (wb_data),
    .raddr_a_i (ra_sel),
    .raddr_b_i (rb_sel),
    .rdata_a_o (rf_a),
    .rdata_b_o (rf_b)
  );

  cpu16_alu #(.DW(DW)) u_alu (
    .op_i (alu_op),
    .a_i  (a_q),
    .b_i  (alu_b),
    .y_o  (alu_y),
    .n_o  (alu_n),
    .z_o  (alu_z),
    .v_o  (alu_v)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q  <= '0;
      pc_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
      mdr_q <= '0;
      n_q   <= 1'b0;
      z_q   <= 1'b0;
      v_q   <= 1'b0;
    end else begin
      case (state)
        ST_FETCH: begin
          ir_q <= mem_rdata_i;
          pc_q <= pc_q + 1'b1;
        end
        ST_DECODE: begin
          a_q <= rf_a;
          b_q <= rf_b;
        end
        ST_EXEC: begin
          res_q <= (op == OP_CALL) ? {{(DW-AW){1'b0}}, pc_q} : alu_y;
          if (sets_flags) begin
            n_q <= alu_n;
            z_q <= alu_z;
            v_q <= alu_v;
          end
          if (op == OP_BR && cond_met(ir_q[11:9], n_q, z_q, v_q)) pc_q <= pc_q + off_ext;
          if (op == OP_CALL) pc_q <= tgt_ext;
          if (op == OP_RET) pc_q <= a_q[AW-1:0];
        end
        ST_MEM: if (op == OP_LD) mdr_q <= mem_rdata_i;
        default: ;
      endcase
    end
  end

  assign mem_addr_o  = (state == ST_MEM) ? res_q[AW-1:0] : pc_q;
  assign mem_wdata_o = b_q;
  assign mem_we_o    = (state == ST_MEM) && (op == OP_ST);
  assign halted_o    = (state == ST_HALT);
endmodule

// File: rtl/cpu16_core_chk.sv
module cpu16_core_chk
  import cpu16_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] mem_addr_i,
  input logic          mem_we_i,
  input logic          halted_i,
  input state_e        state_i
);
  // R8
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> halted_i);

  // R8
  halt_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |-> !mem_we_i);

  // R8
  halt_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> $stable(mem_addr_i));

  // R5
  store_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> !mem_we_i);

  // R5
  fetch_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FETCH) |-> !mem_we_i);

  // R1
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!halted_i && !mem_we_i && mem_addr_i == '0));
endmodule

bind cpu16_core cpu16_core_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_addr_i (mem_addr_o),
  .mem_we_i   (mem_we_o),
  .halted_i   (halted_o),
  .state_i    (state)
);

// File: tb/cpu16_core_test.sv
module cpu16_core_test;
  localparam logic [3:0] K_ADD = 4'd0, K_SUB = 4'd1, K_AND = 4'd2, K_OR = 4'd3;
  localparam logic [3:0] K_ADDI = 4'd4, K_LD = 4'd5, K_ST = 4'd6, K_BR = 4'd7;
  localparam logic [3:0] K_CMP = 4'd8, K_CALL = 4'd9, K_RET = 4'd10;
  localparam logic [15:0] W_HALT = 16'hF000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  addr;
  logic [15:0] wdata, rdata;
  logic        we, halted;
  logic [15:0] mem [1024];
  int          checks = 0, failures = 0;
  int          pc = 0;

  typedef struct {logic [9:0] a; logic [15:0] d; string req;} exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  cpu16_core uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mem_addr_o  (addr),
    .mem_wdata_o (wdata),
    .mem_rdata_i (rdata),
    .mem_we_o    (we),
    .halted_o    (halted)
  );

  assign rdata = mem[addr];
  always @(posedge clk) if (we) mem[addr] <= wdata;

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "store-unexpected", {6'd0, addr, wdata}, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(addr == e.a && wdata == e.d, e.req, {6'd0, addr, wdata}, {6'd0, e.a, e.d});
      end
    end
  end

  function automatic logic [15:0] rr(input logic [3:0] op, input int d, input int s,
                                     input int t);
    logic [2:0] d3, s3, t3;
    d3 = 3'(d); s3 = 3'(s); t3 = 3'(t);
    return {op, d3, s3, t3, 3'b000};
  endfunction

  function automatic logic [15:0] ri(input logic [3:0] op, input int d, input int s,
                                     input int imm);
    logic [2:0] d3, s3;
    logic [5:0] i6;
    d3 = 3'(d); s3 = 3'(s); i6 = 6'(imm);
    return {op, d3, s3, i6};
  endfunction

  function automatic logic [15:0] brw(input int c, input int off);
    logic [2:0] c3;
    logic [8:0] o9;
    c3 = 3'(c); o9 = 9'(off);
    return {K_BR, c3, o9};
  endfunction

  task automatic emit(input logic [15:0] w);
    mem[pc] = w;
    pc++;
  endtask

  task automatic expect_st(input int a, input logic [15:0] d, input string req);
    exp_t e;
    e.a = 10'(a); e.d = d; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = W_HALT;
    pc = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(!halted && !we, "R1 idle in reset", {30'd0, halted, we}, 32'd0);
    rst_n = 1'b1;
    check(addr == 10'd0 && !halted, "R1 first fetch", {21'd0, halted, addr}, 32'd0);
  endtask

  task automatic run_prog(input string name);
    int n = 0;
    do_reset();
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(halted, {"R8 halts ", name}, 32'(halted), 32'd1);
    check(exp_q.size() == 0, {"stores seen ", name}, 32'(exp_q.size()), 32'd0);
    exp_q.delete();
  endtask

  task automatic prog_alu();
    clear_mem();
    mem[1022] = 16'h1234;
    mem[1021] = 16'h7FFF;
    emit(ri(K_ADDI, 1, 0, 5));
    emit(ri(K_ADDI, 2, 0, -3));
    emit(rr(K_ADD, 3, 1, 2));  emit(ri(K_ST, 3, 0, 20)); expect_st(20, 16'h0002, "R2 add");
    emit(rr(K_SUB, 3, 2, 1));  emit(ri(K_ST, 3, 0, 21)); expect_st(21, 16'hFFF8, "R2 sub");
    emit(rr(K_AND, 3, 1, 2));  emit(ri(K_ST, 3, 0, 22)); expect_st(22, 16'h0005, "R2 and");
    emit(rr(K_OR, 3, 1, 2));   emit(ri(K_ST, 3, 0, 23)); expect_st(23, 16'hFFFD, "R3 or/sext");
    emit(ri(K_ADDI, 0, 1, 7));
    emit(rr(K_ADD, 3, 0, 0));  emit(ri(K_ST, 3, 0, 24)); expect_st(24, 16'h0000, "R4 r0 zero");
    emit(ri(K_ADDI, 5, 0, -1));
    emit(ri(K_ST, 1, 5, 0));   expect_st(1023, 16'h0005, "R5 addr truncate");
    emit(ri(K_LD, 6, 5, -1));
    emit(ri(K_ST, 6, 0, 25));  expect_st(25, 16'h1234, "R5 load");
    emit(ri(K_LD, 6, 5, -2));
    emit(ri(K_ADDI, 6, 6, 1));
    emit(ri(K_ST, 6, 0, 26));  expect_st(26, 16'h8000, "R3 wrap");
    emit(W_HALT);
    run_prog("alu");
  endtask

  task automatic prog_branch(input logic [15:0] va, input logic [15:0] vb);
    logic signed [15:0] sa, sb;
    logic tk;
    sa = va; sb = vb;
    clear_mem();
    mem[992] = va;
    mem[993] = vb;
    emit(ri(K_ADDI, 4, 0, -32));
    emit(ri(K_LD, 1, 4, 0));
    emit(ri(K_LD, 2, 4, 1));
    emit(rr(K_ADD, 6, 4, 4));
    for (int c = 0; c < 8; c++) begin
      case (c)
        0: tk = (sa == sb);
        1: tk = (sa != sb);
        2: tk = (sa < sb);
        3: tk = (sa >= sb);
        4: tk = (sa > sb);
        5: tk = (sa <= sb);
        6: tk = 1'b1;
        default: tk = 1'b0;
      endcase
      emit(ri(K_ADDI, 3, 0, 1));
      emit(rr(K_CMP, 0, 1, 2));
      emit(brw(c, 1));
      emit(ri(K_ADDI, 3, 0, 2));
      emit(ri(K_ST, 3, 6, c));
      expect_st(960 + c, tk ? 16'd1 : 16'd2, "R6 branch cond");
    end
    emit(W_HALT);
    run_prog("branch");
  endtask

  task automatic prog_call();
    clear_mem();
    emit(ri(K_ADDI, 1, 0, 3));
    emit(ri(K_ADDI, 2, 0, 0));
    emit(ri(K_ADDI, 2, 2, 4));
    emit(ri(K_ADDI, 1, 1, -1));
    emit(rr(K_CMP, 0, 1, 0));
    emit(brw(4, -4));
    emit(ri(K_ST, 2, 0, 30)); expect_st(30, 16'd12, "R6 backward loop");
    emit({K_CALL, 3'b000, 9'd300});
    emit(ri(K_ST, 3, 0, 31)); expect_st(31, 16'd9, "R7 call body ran");
    emit(ri(K_ST, 7, 0, 29)); expect_st(29, 16'd8, "R7 link value");
    emit(W_HALT);
    mem[300] = ri(K_ADDI, 3, 0, 9);
    mem[301] = {K_RET, 12'd0};
    run_prog("call");
  endtask

  task automatic prog_halt();
    logic [9:0] held;
    clear_mem();
    emit(ri(K_ADDI, 1, 0, 1));
    emit(16'hB000);
    emit(W_HALT);
    emit(ri(K_ST, 1, 0, 20));
    run_prog("halt");
    held = addr;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!halted || we || addr != held) begin
        check(1'b0, "R8 frozen", {21'd0, halted, addr}, {21'd1, held});
        break;
      end
    end
    check(mem[20] == W_HALT, "R8 no store after halt", 32'(mem[20]), 32'(W_HALT));
    do_reset();
    check(!halted, "R1 reset clears halt", 32'(halted), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clear_mem();
    prog_alu();
    prog_branch(16'd5, 16'd5);
    prog_branch(16'd5, 16'd7);
    prog_branch(16'd7, 16'd5);
    prog_branch(16'h7FFF, 16'h8000);
    prog_branch(16'h8000, 16'h0001);
    prog_branch(16'hFFFD, 16'h0002);
    prog_call();
    prog_halt();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule